// File: doc/BRIEF.md
# Ethernet PAUSE Frame Receiver

This block watches the receive byte stream of an Ethernet MAC and picks out flow-control PAUSE frames. Bytes arrive one per clock while `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks its last. On the last byte, `rx_fcs_ok` reports whether the frame check sequence was good.

A frame counts as a PAUSE request only when three fields match:
- the destination address is either the reserved control multicast address or the programmed station address;
- the EtherType is the MAC-control value;
- the control opcode is PAUSE.

The request takes effect at the end of the frame, and only when the checksum is good and receive flow control is enabled. The 16-bit timer field then sets a countdown, counted in slots of 64 byte times. A non-zero value (XOFF) starts or restarts the countdown. A zero value (XON) clears it. While the countdown is non-zero, the transmit side is told to hold off. A byte-time tick input paces the countdown.

Top module: `pause_rx`

## Requirements
- R1: A frame qualifies only if destination bytes 0..5 (first byte = most significant) equal 01-80-C2-00-00-01 or `station_addr`; any other destination causes no pulse and no change of `pause_count`.
- R2: Bytes 12 and 13, high byte first, must equal 0x8808; any other type leaves the pause state untouched.
- R3: Bytes 14 and 15, high byte first, must equal 0x0001; any other opcode is ignored, even with a zero timer.
- R4: A qualifying frame whose timer (bytes 16 and 17, high byte first) is non-zero loads `pause_count` with that value and raises `xoff_pulse`.
- R5: A qualifying frame with a zero timer clears `pause_count` at once and raises `xon_pulse`.
- R6: While `pause_count` is non-zero it drops by one after every 64 cycles with `byte_tick` high, counted from the load. Ticks while the count is zero have no effect.
- R7: With `rx_fc_en` low on the end-of-frame byte, a PAUSE frame changes nothing.
- R8: The action is taken only on the `rx_eof` byte, only with `rx_fcs_ok` high, and only if the frame carried at least 18 bytes. An 18-byte frame is accepted.
- R9: A qualifying XOFF during an active pause replaces the remaining count with the new value and does not add to it.
- R10: After reset, `pause_count` is 0 and `pause_active` is low. `pause_active` is high exactly while `pause_count` is non-zero.
- R11: `xon_pulse` and `xoff_pulse` last one cycle each. They are never high together, and they appear in the cycle after the end-of-frame byte, which is the same cycle `pause_count` takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_fcs_ok | input | 1 | Checksum good, sampled with `rx_eof` |
| rx_fc_en | input | 1 | Receive flow control enable |
| station_addr | input | 48 | Programmed station address, first byte in bits 47:40 |
| byte_tick | input | 1 | One pulse per byte time |
| pause_active | output | 1 | Transmit side must hold off |
| pause_count | output | 16 | Remaining pause in slot units |
| xon_pulse | output | 1 | One-cycle XON event |
| xoff_pulse | output | 1 | One-cycle XOFF event |

## Verification
A corrupted match flag or byte index in the parser shows up as a wrong pulse or a wrong `pause_count` in the cycle after the end-of-frame byte. A fault in the countdown shows up instead as a step out of place. A bad slot prescaler moves the first decrement away from tick 64 after the load. A bad count stays visible at the ports on every later cycle until the next reload. The bench compares all four outputs with a behavioural model on every clock, so any such divergence is reported in the cycle where it first appears.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;
  localparam logic [47:0] CTRL_MCAST   = 48'h0180C2000001;
  localparam logic [15:0] ETYPE_MACCTL = 16'h8808;
  localparam logic [15:0] OPC_PAUSE    = 16'h0001;
  localparam int          POS_TYPE     = 12;
  localparam int          POS_OPC      = 14;
  localparam int          POS_TMR      = 16;
  localparam int          POS_LAST     = 17;
  localparam int          QUANTA_W     = 16;

  typedef struct packed {
    logic                valid;
    logic [QUANTA_W-1:0] quanta;
  } pause_cmd_t;
endpackage

// File: rtl/pause_rx_parser.sv
module pause_rx_parser
  import pause_rx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        rx_fcs_ok,
  input  logic        rx_fc_en,
  input  logic [47:0] station_addr,
  output pause_cmd_t  cmd
);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(POS_LAST + 1);

  logic [IDX_W-1:0]    idx_q, idx_d, cur;
  logic                in_frm_q, in_frm_d;
  logic                mc_q, mc_d, st_q, st_d;
  logic                ty_q, ty_d, op_q, op_d;
  logic [QUANTA_W-1:0] tmr_q, tmr_d;
  logic                beat, mc_hit, st_hit;

  function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [IDX_W-1:0] i);
    logic [7:0] r;
    r = 8'h00;
    for (int b = 0; b < 6; b++) begin
      if (i == IDX_W'(b)) r = a[8*(5-b) +: 8];
    end
    return r;
  endfunction

  always_comb begin
    beat   = rx_valid && (rx_sof || in_frm_q);
    cur    = rx_sof ? '0 : idx_q;
    mc_hit = (rx_data == addr_byte(CTRL_MCAST, cur));
    st_hit = (rx_data == addr_byte(station_addr, cur));

    idx_d    = idx_q;
    in_frm_d = in_frm_q;
    mc_d     = mc_q;
    st_d     = st_q;
    ty_d     = ty_q;
    op_d     = op_q;
    tmr_d    = tmr_q;

    if (beat) begin
      in_frm_d = !rx_eof;
      idx_d    = (cur >= IDX_SAT) ? IDX_SAT : cur + 1'b1;
      if (cur == '0) begin
        mc_d = mc_hit;
        st_d = st_hit;
        ty_d = 1'b0;
        op_d = 1'b0;
      end else if (cur < IDX_W'(6)) begin
        mc_d = mc_q && mc_hit;
        st_d = st_q && st_hit;
      end
      if (cur == IDX_W'(POS_TYPE))     ty_d = (rx_data == ETYPE_MACCTL[15:8]);
      if (cur == IDX_W'(POS_TYPE + 1)) ty_d = ty_q && (rx_data == ETYPE_MACCTL[7:0]);
      if (cur == IDX_W'(POS_OPC))      op_d = (rx_data == OPC_PAUSE[15:8]);
      if (cur == IDX_W'(POS_OPC + 1))  op_d = op_q && (rx_data == OPC_PAUSE[7:0]);
      if (cur == IDX_W'(POS_TMR))      tmr_d[15:8] = rx_data;
      if (cur == IDX_W'(POS_LAST))     tmr_d[7:0]  = rx_data;
    end

    cmd.valid  = beat && rx_eof && rx_fcs_ok && rx_fc_en &&
                 (cur >= IDX_W'(POS_LAST)) && (mc_q || st_q) && ty_q && op_q;
    cmd.quanta = (cur == IDX_W'(POS_LAST)) ? {tmr_q[15:8], rx_data} : tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      in_frm_q <= 1'b0;
      mc_q     <= 1'b0;
      st_q     <= 1'b0;
      ty_q     <= 1'b0;
      op_q     <= 1'b0;
      tmr_q    <= '0;
    end else if (beat) begin
      idx_q    <= idx_d;
      in_frm_q <= in_frm_d;
      mc_q     <= mc_d;
      st_q     <= st_d;
      ty_q     <= ty_d;
      op_q     <= op_d;
      tmr_q    <= tmr_d;
    end
  end
endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer
  import pause_rx_pkg::*;
#(
  parameter int SLOT_TICKS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pause_cmd_t          cmd,
  input  logic                byte_tick,
  output logic                pause_active,
  output logic [QUANTA_W-1:0] pause_count,
  output logic                xon_pulse,
  output logic                xoff_pulse
);
  localparam int               PRE_W    = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_TICKS - 1);

  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [QUANTA_W-1:0] cnt_q, cnt_d;
  logic                xon_q, xon_d, xoff_q, xoff_d;

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    xon_d  = 1'b0;
    xoff_d = 1'b0;
    if (cmd.valid) begin
      cnt_d  = cmd.quanta;
      pre_d  = '0;
      xon_d  = (cmd.quanta == '0);
      xoff_d = (cmd.quanta != '0);
    end else if ((cnt_q != '0) && byte_tick) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        cnt_d = cnt_q - 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      xon_q  <= 1'b0;
      xoff_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      xon_q  <= xon_d;
      xoff_q <= xoff_d;
    end
  end

  assign pause_count  = cnt_q;
  assign pause_active = (cnt_q != '0);
  assign xon_pulse    = xon_q;
  assign xoff_pulse   = xoff_q;
endmodule

// File: rtl/pause_rx.sv
module pause_rx
  import pause_rx_pkg::*;
#(
  parameter int SLOT_TICKS = 64,
  parameter int IDX_W      = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        rx_fcs_ok,
  input  logic        rx_fc_en,
  input  logic [47:0] station_addr,
  input  logic        byte_tick,
  output logic        pause_active,
  output logic [15:0] pause_count,
  output logic        xon_pulse,
  output logic        xoff_pulse
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  pause_cmd_t cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pause_rx_parser #(.IDX_W(IDX_W)) u_parser (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .rx_eof       (rx_eof),
    .rx_data      (rx_data),
    .rx_fcs_ok    (rx_fcs_ok),
    .rx_fc_en     (rx_fc_en),
    .station_addr (station_addr),
    .cmd          (cmd)
  );

  pause_rx_timer #(.SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd          (cmd),
    .byte_tick    (byte_tick),
    .pause_active (pause_active),
    .pause_count  (pause_count),
    .xon_pulse    (xon_pulse),
    .xoff_pulse   (xoff_pulse)
  );
endmodule

// File: rtl/pause_rx_checker.sv
module pause_rx_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        rx_valid,
  input logic        rx_eof,
  input logic        rx_fc_en,
  input logic        byte_tick,
  input logic        pause_active,
  input logic [15:0] pause_count,
  input logic        xon_pulse,
  input logic        xoff_pulse
);
  assert_events_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({xon_pulse, xoff_pulse}));

  assert_xon_clears_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xon_pulse |-> (pause_count == 16'd0));

  assert_xoff_loads_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xoff_pulse |-> (pause_count != 16'd0));

  assert_gated_by_enable_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(rx_fc_en) |-> !(xon_pulse || xoff_pulse));

  assert_eof_required_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(rx_valid && rx_eof) |-> !(xon_pulse || xoff_pulse));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(xon_pulse || xoff_pulse) |->
      ((pause_count == $past(pause_count)) || (pause_count == $past(pause_count) - 16'd1)));

  assert_step_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(xon_pulse || xoff_pulse) && (pause_count != $past(pause_count))) |-> $past(byte_tick));

  assert_rise_by_xoff_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pause_active) |-> xoff_pulse);
endmodule

bind pause_rx pause_rx_checker u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .rx_valid     (rx_valid),
  .rx_eof       (rx_eof),
  .rx_fc_en     (rx_fc_en),
  .byte_tick    (byte_tick),
  .pause_active (pause_active),
  .pause_count  (pause_count),
  .xon_pulse    (xon_pulse),
  .xoff_pulse   (xoff_pulse)
);

// File: tb/pause_rx_bench.sv
module pause_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] MCAST = 48'h0180C2000001;
  localparam logic [47:0] MYADR = 48'h021122334455;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof, rx_fcs_ok, rx_fc_en, byte_tick;
  logic [7:0]  rx_data;
  logic [47:0] station_addr;
  logic        pause_active, xon_pulse, xoff_pulse;
  logic [15:0] pause_count;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  tick_g   = 1'b0;
  bit  done     = 1'b0;

  byte unsigned mq[$];
  bit  m_in;
  int  m_cnt, m_pre;
  bit  m_xon, m_xoff;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_rx u_pause_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_fcs_ok(rx_fcs_ok), .rx_fc_en(rx_fc_en),
    .station_addr(station_addr), .byte_tick(byte_tick), .pause_active(pause_active),
    .pause_count(pause_count), .xon_pulse(xon_pulse), .xoff_pulse(xoff_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    logic [47:0] da;
    bit          commit;
    int          q16;
    if (!rst_n) begin
      mq.delete(); m_in = 0; m_cnt = 0; m_pre = 0; m_xon = 0; m_xoff = 0;
    end else begin
      commit = 0; q16 = 0; m_xon = 0; m_xoff = 0; da = '0;
      if (rx_valid && (rx_sof || m_in)) begin
        if (rx_sof) mq.delete();
        mq.push_back(rx_data);
        m_in = !rx_eof;
        if (rx_eof && rx_fcs_ok && rx_fc_en && mq.size() >= 18) begin
          for (int i = 0; i < 6; i++) da = {da[39:0], mq[i]};
          if ((da == MCAST || da == station_addr) &&
              {mq[12], mq[13]} == 16'h8808 && {mq[14], mq[15]} == 16'h0001) begin
            commit = 1;
            q16 = int'({mq[16], mq[17]});
          end
        end
      end
      if (commit) begin
        m_cnt = q16; m_pre = 0; m_xon = (q16 == 0); m_xoff = (q16 != 0);
      end else if (m_cnt > 0 && byte_tick) begin
        m_pre++;
        if (m_pre == 64) begin m_pre = 0; m_cnt--; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6/R9 count vs model", int'(pause_count), m_cnt);
      check("R10 active vs model", int'(pause_active), int'(m_cnt != 0));
      check("R5/R11 xon vs model", int'(xon_pulse), int'(m_xon));
      check("R4/R11 xoff vs model", int'(xoff_pulse), int'(m_xoff));
    end
  end

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs_ok = 0; rx_data = 8'h00;
      byte_tick = tk;
      @(negedge clk);
    end
    byte_tick = 0;
  endtask

  task automatic send_frame(input logic [47:0] da, input logic [15:0] ty,
                            input logic [15:0] op, input logic [15:0] tm,
                            input int len, input bit fcs);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      if (i < 6)       b = da[8*(5-i) +: 8];
      else if (i < 12) b = 8'hA0 + 8'(i);
      else if (i == 12) b = ty[15:8];
      else if (i == 13) b = ty[7:0];
      else if (i == 14) b = op[15:8];
      else if (i == 15) b = op[7:0];
      else if (i == 16) b = tm[15:8];
      else if (i == 17) b = tm[7:0];
      else              b = 8'h00;
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_fcs_ok = fcs && (i == len - 1); rx_data = b; byte_tick = tick_g;
      @(negedge clk);
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs_ok = 0; byte_tick = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs_ok = 0; rx_data = 0;
    byte_tick = 0; rx_fc_en = 1; station_addr = MYADR;
    repeat (3) @(negedge clk);
    check("R10 reset count", int'(pause_count), 0);
    check("R10 reset active", int'(pause_active), 0);
    check("R11 reset pulses", int'(xon_pulse | xoff_pulse), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // XOFF to multicast, timer 2
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd2, 64, 1);
    check("R4 xoff pulse", int'(xoff_pulse), 1);
    check("R4 R1 count loaded", int'(pause_count), 2);
    check("R10 active high", int'(pause_active), 1);
    idle(1, 0);
    check("R11 pulse one cycle", int'(xoff_pulse), 0);
    idle(63, 1);
    check("R6 no step before slot", int'(pause_count), 2);
    idle(1, 1);
    check("R6 step after 64 ticks", int'(pause_count), 1);
    idle(64, 1);
    check("R6 expired", int'(pause_count), 0);
    check("R10 active low", int'(pause_active), 0);
    idle(100, 1);
    check("R6 idle ticks ignored", int'(pause_count), 0);

    // station address, timer 3
    send_frame(MYADR, 16'h8808, 16'h0001, 16'd3, 60, 1);
    check("R1 station match", int'(pause_count), 3);
    // XON
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd0, 60, 1);
    check("R5 xon pulse", int'(xon_pulse), 1);
    check("R5 xon clears", int'(pause_count), 0);
    // wrong destination
    send_frame(48'h0180C2000002, 16'h8808, 16'h0001, 16'd5, 60, 1);
    check("R1 bad address ignored", int'(pause_count), 0);
    check("R1 no pulse", int'(xoff_pulse), 0);

    send_frame(MYADR, 16'h8808, 16'h0001, 16'd4, 60, 1);
    check("R4 load 4", int'(pause_count), 4);
    send_frame(MCAST, 16'h8809, 16'h0001, 16'd9, 60, 1);
    check("R2 bad type ignored", int'(pause_count), 4);
    send_frame(MCAST, 16'h8808, 16'h0002, 16'd0, 60, 1);
    check("R3 bad opcode ignored", int'(pause_count), 4);
    check("R3 no xon", int'(xon_pulse), 0);
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd0, 60, 0);
    check("R8 bad fcs ignored", int'(pause_count), 4);
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd0, 17, 1);
    check("R8 short frame ignored", int'(pause_count), 4);
    rx_fc_en = 0;
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd0, 60, 1);
    check("R7 disabled ignored", int'(pause_count), 4);
    rx_fc_en = 1;
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd1, 60, 1);
    check("R9 reload not add", int'(pause_count), 1);
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd0, 60, 1);
    check("R5 cancel", int'(pause_count), 0);

    // ticks during reception, load restarts slot
    tick_g = 1;
    send_frame(MYADR, 16'h8808, 16'h0001, 16'd1, 40, 1);
    tick_g = 0;
    check("R4 load with ticks", int'(pause_count), 1);
    idle(64, 1);
    check("R6 slot from load", int'(pause_count), 0);

    // minimum 18-byte frame
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd7, 18, 1);
    check("R8 18-byte accepted", int'(pause_count), 7);
    send_frame(MCAST, 16'h8808, 16'h0001, 16'd0, 18, 1);
    check("R5 final xon", int'(pause_count), 0);
    idle(5, 0);
    finish_run();
  end
endmodule